// File: doc/BRIEF.md
# Two-Wire Wiper Position Slave

This block is a write-only slave on a two-wire serial bus. It holds two 8-bit wiper position codes. A master sets them with a fixed three-byte frame. The frame opens with a START and the address byte. The address byte carries a 7-bit slave address and a write/no-operation flag. The command byte follows and picks the target wipers. The data byte comes last, and a STOP closes the frame. The slave never sends data back. Its only output on the bus is an enable that pulls SDA low for each acknowledge.

The bus lines come from open-drain pads. Each passes through a two-flop synchronizer, and START, STOP and clock edges are found in the system clock domain. Three strap inputs set the low address bits, so up to eight of these slaves can share one bus. The received data waits in a holding register and reaches the wipers only at a STOP that ends a complete frame. A write-protect input blocks that commit. When write-protect is released, the slave reloads the wipers from the last complete frame.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset, both wiper outputs read 0x80 and the SDA pull enable is low.
- R2: The address byte is taken MSB first on SCL rising edges. Bits 7..4 must equal 0101, and bits 3..1 must equal strap[2], strap[1], strap[0]. On a match, the slave pulls SDA low during the ninth clock of the byte.
- R3: On an address mismatch, the slave acknowledges nothing, neither that byte nor any later byte, until the next START. No wiper changes.
- R4: The low two bits of the command byte pick the target. Command 0x01 loads wiper A, 0x02 loads wiper B, and 0x03 loads both. The command byte and the data byte are each acknowledged once the address has matched.
- R5: A command value above 0x03 is acknowledged, and the frame changes no wiper.
- R6: Wipers change only at the STOP that ends a complete address+command+data frame. A STOP after fewer bytes leaves both wipers unchanged.
- R7: When address bit 0 (the flag) is 1, the slave still acknowledges all three bytes but changes no wiper.
- R8: While write-protect is high, a complete frame changes no wiper.
- R9: A falling edge of write-protect loads the data of the last complete write frame into the wipers that frame selected. If that frame selected none, nothing changes.
- R10: A repeated START in the middle of a frame discards the partial frame, and address reception starts over.
- R11: The acknowledge pull is asserted only while SCL is low. It stays on for the whole high phase of the ninth clock and is released after that clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| strap_i | input | 3 | Address straps {A2,A1,A0} |
| wp_i | input | 1 | Write-protect, high blocks commits |
| sda_pull_o | output | 1 | High pulls SDA low (acknowledge) |
| wiper_a_o | output | 8 | Wiper A position code |
| wiper_b_o | output | 8 | Wiper B position code |

## Verification
Frames for each of the three valid command codes show whether the command decode routes the data to the right wiper. Out-of-range commands, no-operation frames, frames cut short by STOP and frames broken by a repeated START all get acknowledged in part or in full. They must still leave the wipers untouched, which separates the acknowledge from the commit. Matching and mismatching addresses under two strap settings test the address compare. Frames sent under write-protect, followed by a release, show whether the block keeps the last complete frame rather than the last received byte.

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
  parameter int          DW        = 8,
  parameter logic [3:0]  ADDR_HI   = 4'b0101,
  parameter logic [DW-1:0] RST_CODE = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          wp_i,
  output logic          sda_pull_o,
  output logic [DW-1:0] wiper_a_o,
  output logic [DW-1:0] wiper_b_o
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_DATA, S_DONE, S_SKIP} st_t;

  st_t st;
  logic [1:0] scl_sync, sda_sync;
  logic scl_d, sda_d, wp_d;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [DW-1:0] hold, last_data;
  logic [1:0] sel, last_sel;
  logic nop, have_frame, ack;

  wire scl_v = scl_sync[1];
  wire sda_v = sda_sync[1];
  wire scl_rise = scl_v & ~scl_d;
  wire scl_fall = ~scl_v & scl_d;
  wire start_det = scl_v & scl_d & sda_d & ~sda_v;
  wire stop_det  = scl_v & scl_d & ~sda_d & sda_v;
  wire busy = (st == S_ADDR) || (st == S_CMD) || (st == S_DATA);
  wire addr_hit = (shreg[7:1] == {ADDR_HI, strap_i});
  wire wp_fall = wp_d & ~wp_i;

  assign sda_pull_o = ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_v;
      sda_d    <= sda_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      hold       <= '0;
      sel        <= '0;
      nop        <= 1'b0;
      ack        <= 1'b0;
      last_data  <= '0;
      last_sel   <= '0;
      have_frame <= 1'b0;
      wp_d       <= 1'b0;
      wiper_a_o  <= RST_CODE;
      wiper_b_o  <= RST_CODE;
    end else begin
      wp_d <= wp_i;
      if (wp_fall && have_frame) begin
        if (last_sel[0]) wiper_a_o <= last_data;
        if (last_sel[1]) wiper_b_o <= last_data;
      end
      if (start_det) begin
        st      <= S_ADDR;
        bit_cnt <= '0;
        ack     <= 1'b0;
      end else if (stop_det) begin
        if (st == S_DONE && !nop) begin
          last_sel   <= sel;
          last_data  <= hold;
          have_frame <= 1'b1;
          if (!wp_i) begin
            if (sel[0]) wiper_a_o <= hold;
            if (sel[1]) wiper_b_o <= hold;
          end
        end
        st      <= S_IDLE;
        bit_cnt <= '0;
        ack     <= 1'b0;
      end else if (busy) begin
        if (scl_rise && bit_cnt != 4'd8) begin
          shreg   <= {shreg[6:0], sda_v};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && bit_cnt == 4'd8) begin
          if (!ack) begin
            case (st)
              S_ADDR: begin
                if (addr_hit) begin
                  ack <= 1'b1;
                  nop <= shreg[0];
                end else begin
                  st <= S_SKIP;
                end
              end
              S_CMD: begin
                ack <= 1'b1;
                sel <= (shreg[7:2] == 6'd0) ? shreg[1:0] : 2'b00;
              end
              default: begin
                ack  <= 1'b1;
                hold <= shreg[DW-1:0];
              end
            endcase
          end else begin
            ack     <= 1'b0;
            bit_cnt <= '0;
            case (st)
              S_ADDR:  st <= S_CMD;
              S_CMD:   st <= S_DATA;
              default: st <= S_DONE;
            endcase
          end
        end
      end
    end
  end
endmodule

module wiper_i2c_slave_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_v,
  input logic          start_det,
  input logic          stop_det,
  input logic          wp_d,
  input logic          wp_i,
  input logic          sda_pull_o,
  input logic [2:0]    st,
  input logic [3:0]    bit_cnt,
  input logic [DW-1:0] wiper_a_o,
  input logic [DW-1:0] wiper_b_o
);
  AST_ONLY_AT_STOP_OR_WP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stop_det) && !$past(wp_d && !wp_i)) |-> ($stable(wiper_a_o) && $stable(wiper_b_o))); // R6
  AST_WP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp_i) |-> ($stable(wiper_a_o) && $stable(wiper_b_o))); // R8
  AST_PULL_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_pull_o != $past(sda_pull_o)) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_v)); // R11
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5) |-> !sda_pull_o); // R3
  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (bit_cnt == 4'd8)); // R2
endmodule

bind wiper_i2c_slave wiper_i2c_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_v(scl_v), .start_det(start_det), .stop_det(stop_det),
  .wp_d(wp_d), .wp_i(wp_i), .sda_pull_o(sda_pull_o), .st(st), .bit_cnt(bit_cnt),
  .wiper_a_o(wiper_a_o), .wiper_b_o(wiper_b_o)
);

// File: tb/sim_wiper_i2c_slave.sv
`timescale 1ns/1ps
module sim_wiper_i2c_slave;
  localparam int Q = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b000;
  logic pull;
  logic [7:0] wa, wb;
  wire sda_bus = sda_m & ~pull;

  wiper_i2c_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .wp_i(wp), .sda_pull_o(pull), .wiper_a_o(wa), .wiper_b_o(wb));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, hold_off = 0;
  logic [7:0] exp_a = 8'h80, exp_b = 8'h80, last_data = 8'h00;
  logic [1:0] last_sel = 2'b00;
  bit have = 0, done = 0;
  string cur = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (hold_off > 0) hold_off--;
      else begin
        chk(wa == exp_a, cur, "wiper A vs model", wa, exp_a);
        chk(wb == exp_b, cur, "wiper B vs model", wb, exp_b);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic half(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half();
  endtask

  task automatic bus_stop();
    sda_m = 0; half(); scl_m = 1; half(); sda_m = 1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl_m = 1; half(); scl_m = 0; half();
    end
    sda_m = 1; half(); scl_m = 1;
    repeat (2) @(negedge clk);
    chk(pull == exp_ack, req, "ack at ninth rise", pull, exp_ack);
    repeat (Q - 2) @(negedge clk);
    chk(pull == exp_ack, req, "ack end of ninth high (R11)", pull, exp_ack);
    scl_m = 0; half();
    chk(pull == 1'b0, "R11", "pull released after ninth clock", pull, 0);
  endtask

  function automatic bit hit(input logic [7:0] a);
    return a[7:1] == {4'b0101, strap};
  endfunction

  task automatic model_commit(input logic [7:0] cmd, input logic [7:0] d, input bit nop);
    logic [1:0] s;
    hold_off = 10;
    if (nop) return;
    s = (cmd < 8'd4) ? cmd[1:0] : 2'b00;
    last_sel = s; last_data = d; have = 1;
    if (!wp) begin
      if (s[0]) exp_a = d;
      if (s[1]) exp_b = d;
    end
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk);
    if (wp && !v && have) begin
      if (last_sel[0]) exp_a = last_data;
      if (last_sel[1]) exp_b = last_data;
    end
    hold_off = 10;
    wp = v;
    repeat (20) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d, input string req);
    bit h;
    h = hit(a);
    cur = req;
    bus_start();
    send_byte(a, h, req);
    send_byte(c, h, req);
    send_byte(d, h, req);
    bus_stop();
    if (h) model_commit(c, d, a[0]);
    else hold_off = 10;
    half(); half();
  endtask

  task automatic expect_w(input logic [7:0] ea, input logic [7:0] eb, input string req);
    chk(wa == ea, req, "wiper A", wa, ea);
    chk(wb == eb, req, "wiper B", wb, eb);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(wa == 8'h80 && wb == 8'h80, "R1", "reset wipers", {wa, wb}, 16'h8080);
    chk(pull == 1'b0, "R1", "reset pull", pull, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);

    frame(8'h50, 8'h01, 8'h3C, "R4");
    expect_w(8'h3C, 8'h80, "R4");
    frame(8'h50, 8'h02, 8'hA5, "R4");
    expect_w(8'h3C, 8'hA5, "R4");
    frame(8'h50, 8'h03, 8'h11, "R4");
    expect_w(8'h11, 8'h11, "R4");
    frame(8'h50, 8'h04, 8'hFF, "R5");
    frame(8'h50, 8'h81, 8'hEE, "R5");
    expect_w(8'h11, 8'h11, "R5");

    strap = 3'b101;
    frame(8'h50, 8'h01, 8'h22, "R3");
    expect_w(8'h11, 8'h11, "R3");
    frame(8'h5A, 8'h01, 8'h77, "R2");
    expect_w(8'h77, 8'h11, "R2");
    frame(8'h5B, 8'h03, 8'h00, "R7");
    expect_w(8'h77, 8'h11, "R7");

    cur = "R6";
    bus_start();
    send_byte(8'h5A, 1'b1, "R6");
    send_byte(8'h02, 1'b1, "R6");
    bus_stop();
    hold_off = 10;
    half(); half();
    expect_w(8'h77, 8'h11, "R6");

    set_wp(1'b1);
    frame(8'h5A, 8'h02, 8'h42, "R8");
    expect_w(8'h77, 8'h11, "R8");
    cur = "R9";
    set_wp(1'b0);
    expect_w(8'h77, 8'h42, "R9");

    set_wp(1'b1);
    frame(8'h5A, 8'h01, 8'h55, "R8");
    frame(8'h5A, 8'h09, 8'h66, "R9");
    cur = "R9";
    set_wp(1'b0);
    expect_w(8'h77, 8'h42, "R9");

    cur = "R10";
    bus_start();
    send_byte(8'h5A, 1'b1, "R10");
    send_byte(8'h01, 1'b1, "R10");
    for (int i = 0; i < 3; i++) begin
      sda_m = i[0]; half(); scl_m = 1; half(); scl_m = 0; half();
    end
    frame(8'h5A, 8'h02, 8'h99, "R10");
    expect_w(8'h77, 8'h99, "R10");

    strap = 3'b000;
    frame(8'h50, 8'h01, 8'h0F, "R2");
    expect_w(8'h0F, 8'h99, "R2");

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule